// File: doc/BRIEF.md
# Flash Lock-Bit Set Sequencer

This controller sits on the host side of an external parallel NOR-style flash and runs the command flow that sets the lock bit of one block. A one-cycle start pulse hands over a block address and a flag that marks the operation as the final one of a batch. The controller then drives a simple synchronous bus master port toward the flash. It writes the two-cycle lock command, switches the device to status output and reads the status register until the device's internal state machine reports ready.

Several lock operations can be chained. Only the operation flagged as final has its status decoded into a result code. When that check finds an error, the controller clears the device's sticky error flags. It then puts the device back into read-array mode. A programmable poll limit bounds the wait for ready, and the result code stays on its port until the next operation finishes.

Bus timing: every port output is decoded from the controller's state. A write happens in each cycle where `bus_wr` is high. `bus_rdata` must be valid in the same cycle as `bus_rd` and is sampled at the closing clock edge. Status byte layout: bit 7 ready, bit 5 sequence-class error, bit 4 lock failure, bit 3 programming-voltage error.

Top module: `flash_lock_seq`

## Requirements
- R1: A start accepted in an idle cycle causes a write of 60h to the block address in the next cycle, followed in the cycle after that by a write of 01h to the same address.
- R2: In the cycle after the 01h write, the controller writes 70h. It then asserts `bus_rd` in every cycle until a read returns bit 7 = 1.
- R3: If `max(poll_limit,1)` consecutive reads all return bit 7 = 0, the controller ends the operation with result 4 and issues no further writes.
- R4: On the final operation, a ready status with bit 3 = 1 gives result 1, whatever bits 4 and 5 hold.
- R5: On the final operation with bit 3 = 0, the result is 2 if bits 4 and 5 are both 1. It is 3 if only bit 4 is 1, 6 if only bit 5 is 1, and 0 if all three are 0.
- R6: On an operation not flagged as final, a ready status ends the operation with result 5. No status decode happens and no further writes are issued.
- R7: When the final check finds any of bits 3, 4 or 5 set, the controller writes 50h in the cycle after the ready read, before the read-array write.
- R8: On the final operation, the controller writes FFh after the status check (after the 50h write when one is issued). Done follows in the next cycle.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start through the done cycle. `result` changes only in the done cycle and holds until the next done.
- R10: A start pulse while `busy` is high is ignored. Its address and flag have no effect on the running operation.
- R11: `bus_wr` and `bus_rd` are never high in the same cycle. Every write goes to the block address captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for one lock operation |
| blk_addr | input | AW | Block address of the operation |
| last_op | input | 1 | Marks the final operation of a batch |
| poll_limit | input | TW | Maximum number of busy status reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code (0 ok, 1 voltage, 2 sequence, 3 lock fail, 4 timeout, 5 unchecked, 6 other) |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | 8 | Flash bus write data |
| bus_wr | output | 1 | Flash bus write strobe |
| bus_rd | output | 1 | Flash bus read strobe |
| bus_rdata | input | 8 | Flash bus read data, valid with `bus_rd` |

## Verification
The bench builds the block with a 12-bit address and a 4-bit poll counter. With these sizes the largest poll limit is 15, so a ready bit seen on exactly the fifteenth read and a busy run one read longer both fit in a short test. A poll limit of zero is covered as well. A behavioural flash responder with a programmable ready delay and injectable sticky error bits allows each error combination to be set up. It also allows errors to build up across a chained batch.

// File: rtl/flash_lock_seq.sv
module flash_lock_seq #(
  parameter int AW = 24,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] blk_addr,
  input  logic          last_op,
  input  logic [TW-1:0] poll_limit,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          bus_wr,
  output logic          bus_rd,
  input  logic [7:0]    bus_rdata
);

  localparam logic [2:0] RES_OK   = 3'd0;
  localparam logic [2:0] RES_VOLT = 3'd1;
  localparam logic [2:0] RES_SEQ  = 3'd2;
  localparam logic [2:0] RES_LOCK = 3'd3;
  localparam logic [2:0] RES_TMO  = 3'd4;
  localparam logic [2:0] RES_PART = 3'd5;
  localparam logic [2:0] RES_OTH  = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CONF, ST_RDST, ST_POLL, ST_CLR, ST_ARR, ST_FIN
  } st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic          last_q;
  logic [TW-1:0] cnt;
  logic [2:0]    res_q;
  logic [2:0]    dec;
  logic          ready, anyerr, limit_hit;

  assign ready     = bus_rdata[7];
  assign anyerr    = |bus_rdata[5:3];
  assign limit_hit = ({1'b0, cnt} + 1'b1) >= {1'b0, poll_limit};

  always_comb begin
    if (bus_rdata[3])                    dec = RES_VOLT;
    else if (bus_rdata[4] && bus_rdata[5]) dec = RES_SEQ;
    else if (bus_rdata[4])               dec = RES_LOCK;
    else if (bus_rdata[5])               dec = RES_OTH;
    else                                 dec = RES_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      last_q <= 1'b0;
      cnt    <= '0;
      res_q  <= RES_OK;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          addr_q <= blk_addr;
          last_q <= last_op;
          st     <= ST_SETUP;
        end
        ST_SETUP: st <= ST_CONF;
        ST_CONF:  st <= ST_RDST;
        ST_RDST: begin
          cnt <= '0;
          st  <= ST_POLL;
        end
        ST_POLL: begin
          if (ready) begin
            if (!last_q) begin
              res_q <= RES_PART;
              st    <= ST_FIN;
            end else begin
              res_q <= dec;
              st    <= anyerr ? ST_CLR : ST_ARR;
            end
          end else if (limit_hit) begin
            res_q <= RES_TMO;
            st    <= ST_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CLR:  st <= ST_ARR;
        ST_ARR:  st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [2:0] res_out;
  always_ff @(posedge clk) begin
    if (!rst_n)              res_out <= RES_OK;
    else if (st == ST_FIN)   res_out <= res_out;
    else if (st == ST_POLL && (ready || limit_hit) && (!ready || !last_q)) res_out <= ready ? RES_PART : RES_TMO;
    else if (st == ST_ARR)   res_out <= res_q;
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);
  assign result   = res_out;
  assign bus_addr = addr_q;
  assign bus_wr   = (st == ST_SETUP) || (st == ST_CONF) || (st == ST_RDST) ||
                    (st == ST_CLR) || (st == ST_ARR);
  assign bus_rd   = (st == ST_POLL);

  always_comb begin
    case (st)
      ST_SETUP: bus_wdata = 8'h60;
      ST_CONF:  bus_wdata = 8'h01;
      ST_RDST:  bus_wdata = 8'h70;
      ST_CLR:   bus_wdata = 8'h50;
      ST_ARR:   bus_wdata = 8'hFF;
      default:  bus_wdata = 8'h00;
    endcase
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  assert_confirm_after_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata == 8'h01) |-> $past(bus_wr && bus_wdata == 8'h60));

  assert_timeout_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_TMO) |-> $past(bus_rd));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done)) |-> $stable(result));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> (!bus_wr || $stable(bus_addr)));

  assert_clear_before_array_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata == 8'h50) |=> (bus_wr && bus_wdata == 8'hFF));

endmodule

// File: tb/flash_lock_seq_tb_top.sv
module flash_lock_seq_tb_top;
  localparam int AW = 12;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] blk_addr = '0;
  logic          last_op = 1'b0;
  logic [TW-1:0] poll_limit = '0;
  logic          busy, done, bus_wr, bus_rd;
  logic [2:0]    result;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  flash_lock_seq #(.AW(AW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
    .last_op(last_op), .poll_limit(poll_limit), .busy(busy), .done(done),
    .result(result), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  // behavioural flash responder
  int         rsp_delay = 0;
  logic [2:0] rsp_inj = 3'b000;
  int         f_cnt = 0;
  logic [2:0] f_err = 3'b000;
  logic [7:0] f_prev = 8'h00;

  always @(posedge clk) begin
    if (bus_wr) begin
      if (bus_wdata == 8'h01 && f_prev == 8'h60) begin
        f_cnt <= rsp_delay;
        f_err <= f_err | rsp_inj;
      end else begin
        if (f_cnt > 0) f_cnt <= f_cnt - 1;
        if (bus_wdata == 8'h50) f_err <= 3'b000;
      end
      f_prev <= bus_wdata;
    end else if (f_cnt > 0) f_cnt <= f_cnt - 1;
  end
  assign bus_rdata = {(f_cnt == 0), 1'b0, f_err[2], f_err[1], f_err[0], 3'b000};

  int errors = 0;
  int checks = 0;
  logic [2:0] m_acc = 3'b000;
  int    tk[$];
  int    td[$];
  string tt[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input logic [2:0] e);
    if (e[0]) return 1;
    if (e[1] && e[2]) return 2;
    if (e[1]) return 3;
    if (e[2]) return 6;
    return 0;
  endfunction

  task automatic push(input int k, input int d, input string t);
    tk.push_back(k); td.push_back(d); tt.push_back(t);
  endtask

  // kinds: 1 write, 2 read, 3 done
  task automatic run_op(input int addr, input bit last, input int lim, input int dly,
                        input logic [2:0] inj, input int glitch_at);
    int lim_e, need, exp_res, idx;
    rsp_delay = dly;
    rsp_inj = inj;
    tk.delete(); td.delete(); tt.delete();
    push(1, 8'h60, "R1"); push(1, 8'h01, "R1"); push(1, 8'h70, "R2");
    m_acc = m_acc | inj;
    lim_e = (lim == 0) ? 1 : lim;
    need = (dly < 1) ? 1 : dly;
    if (need > lim_e) begin
      for (int i = 0; i < lim_e; i++) push(2, 0, "R3");
      exp_res = 4;
    end else begin
      for (int i = 0; i < need; i++) push(2, 0, "R2");
      if (!last) exp_res = 5;
      else begin
        exp_res = exp_code(m_acc);
        if (m_acc != 3'b000) begin
          push(1, 8'h50, "R7");
          m_acc = 3'b000;
        end
        push(1, 8'hFF, "R8");
      end
    end
    push(3, 0, "R9");

    @(negedge clk);
    blk_addr = addr[AW-1:0]; last_op = last; poll_limit = lim[TW-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    while (tk.size() > 0) begin
      int k, d; string t;
      k = tk.pop_front(); d = td.pop_front(); t = tt.pop_front();
      check(bus_wr == (k == 1), {t, " wr strobe"}, bus_wr, k == 1);
      check(bus_rd == (k == 2), {t, " rd strobe"}, bus_rd, k == 2);
      check(done == (k == 3), {t, " done"}, done, k == 3);
      check(busy == 1'b1, "R9 busy", busy, 1);
      check(!(bus_wr && bus_rd), "R11 strobe overlap", {bus_wr, bus_rd}, 0);
      if (k == 1) begin
        check(bus_wdata == d[7:0], {t, " wdata"}, bus_wdata, d);
        check(bus_addr == addr[AW-1:0], "R11/R10 addr", bus_addr, addr[AW-1:0]);
      end
      if (k == 3) begin
        string rt;
        rt = (exp_res == 4) ? "R3" : (exp_res == 5) ? "R6" :
             (exp_res == 1) ? "R4" : "R5";
        check(result == exp_res[2:0], {rt, " result"}, result, exp_res);
      end
      if (idx == glitch_at) begin
        blk_addr = ~addr[AW-1:0]; last_op = ~last; start = 1'b1;
      end else start = 1'b0;
      idx++;
      @(negedge clk);
    end
    start = 1'b0;
    check(!busy && !done && !bus_wr && !bus_rd, "R9 idle after done", {busy, done, bus_wr, bus_rd}, 0);
    check(result == exp_res[2:0], "R9 result held", result, exp_res);
    repeat (2) @(negedge clk);
    check(result == exp_res[2:0], "R9 result held later", result, exp_res);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !bus_wr && !bus_rd && result == 3'd0, "R9 reset state",
          {busy, done, bus_wr, bus_rd, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(12'h123, 1'b1, 10, 3, 3'b000, -1);   // R5 success
    run_op(12'h200, 1'b1, 10, 0, 3'b001, -1);   // R4 voltage, R7 clear
    run_op(12'h201, 1'b1, 10, 2, 3'b111, -1);   // R4 priority
    run_op(12'h202, 1'b1, 10, 1, 3'b110, -1);   // R5 sequence
    run_op(12'h203, 1'b1, 10, 4, 3'b010, -1);   // R5 lock fail
    run_op(12'h204, 1'b1, 10, 2, 3'b100, -1);   // R5 other
    run_op(12'h300, 1'b0, 10, 2, 3'b010, -1);   // R6 chained, unchecked
    run_op(12'h301, 1'b0, 10, 5, 3'b000, -1);   // R6
    run_op(12'h302, 1'b1, 10, 1, 3'b000, -1);   // R5 sticky lock fail
    run_op(12'h400, 1'b1, 4, 9, 3'b000, -1);    // R3 timeout
    run_op(12'h401, 1'b1, 0, 2, 3'b000, -1);    // R3 zero limit
    run_op(12'h402, 1'b1, 15, 15, 3'b000, -1);  // R3 boundary ready on last read
    run_op(12'h403, 1'b1, 15, 16, 3'b000, -1);  // R3 one read too many
    run_op(12'h404, 1'b1, 15, 16, 3'b000, -1);  // drain responder
    run_op(12'h500, 1'b1, 10, 3, 3'b000, 2);    // R10 start while busy
    run_op(12'h501, 1'b1, 10, 2, 3'b010, 6);    // R10 start in final writes
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule